// File: doc/BRIEF.md
# Translation Lookup for a Software-Loaded TLB

This block maps an effective address to a real address by scanning a table of translation entries that software fills one at a time. Each entry carries a valid flag, a virtual page number, a page-size code, a process tag, an address-space bit, a real page number and an eight-bit rights field. The rights field holds two nibbles. One applies in user mode and the other in supervisor mode.

A lookup is started by a one-cycle request strobe. The request carries the address, a write flag, a fetch flag, the privilege level, the instruction-side and data-side address-space bits, and the current process tag. All entries are compared in parallel. A priority pick then reproduces an ascending scan that runs to the first entry that both matches and grants the access. A matching entry that refuses the access does not end the scan. A matching entry that lies in the other address space does not end it either. A later entry can still grant the access.

The outcome, the real address and the deciding rights nibble are registered. They are presented one cycle after the strobe, together with a done pulse. A simple write port replaces one entry per clock.

The control is a two-state machine with states IDLE and REPORT:
- IDLE goes to REPORT when a request arrives. It stays in IDLE otherwise.
- REPORT stays in REPORT when a new request arrives in the same cycle (back-to-back). It returns to IDLE otherwise.
- The done output is high exactly while the machine is in REPORT.

Top module: `xlat_lookup`

## Requirements
- R1: After reset the outputs are: done low, status 01 (miss), real address zero and rights nibble zero. Every entry is invalid, so a first lookup reports a miss.
- R2: A request strobe sampled at a clock edge produces done high for exactly the following cycle, with the result valid in that cycle. Back-to-back strobes give back-to-back done pulses, and done is low when no request preceded it.
- R3: An entry matches when all of the following hold:
  - it is valid;
  - its process tag equals the request tag, or is zero;
  - its page number equals the address in every bit at or above the page boundary.
  A size code c puts the boundary at bit 10+2c, capped at the address width, in which case every address matches.
- R4: On success the real address is the entry's real page number above the page boundary, joined with the request address bits below it.
- R5: Entries are considered in ascending index order. The lowest-index entry that matches, lies in the right address space and grants the access decides the result, even when higher entries would also grant it.
- R6: The rights nibble is bits 3:0 in user mode and bits 7:4 in supervisor mode. Within a nibble, bit 0 is read, bit 1 is write and bit 2 is execute. The rights output is the nibble of the deciding entry: the granting entry on success, or the highest-index refusing entry on a fault.
- R7: For a fetch, an entry whose space bit differs from the instruction-side bit is skipped. For a data access, the entry's space bit is compared with the data-side bit. A skipped entry neither grants nor faults.
- R8: A fetch needs execute rights. If every eligible entry lacks them, the status is 11 (execute fault). If a later eligible entry has them, the fetch succeeds.
- R9: A data read needs read rights and a data write needs write rights. If every eligible entry refuses, the status is 10 (data fault). If a later eligible entry grants, the access succeeds.
- R10: When no entry is eligible, the status is 01 and the rights nibble is zero. The real address output changes only on a successful lookup and otherwise holds its last value.
- R11: When the write port is enabled, the entry at the write index is replaced at that clock edge. A lookup requested in the same cycle sees the old contents, and the next lookup sees the new ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Replace one entry this cycle |
| wr_idx | input | 6 | Entry index to replace |
| wr_valid | input | 1 | Valid flag of new entry |
| wr_epn | input | 32 | Virtual page number (bits below the page boundary ignored) |
| wr_size | input | 4 | Page size code |
| wr_pid | input | 8 | Process tag (zero = global) |
| wr_space | input | 1 | Address-space bit |
| wr_rpn | input | 32 | Real page number |
| wr_perm | input | 8 | Rights: 7:4 supervisor, 3:0 user |
| req | input | 1 | Lookup strobe |
| req_addr | input | 32 | Effective address |
| req_write | input | 1 | Data write (else read) |
| req_fetch | input | 1 | Instruction fetch |
| req_super | input | 1 | Supervisor privilege |
| req_ispace | input | 1 | Instruction-side address space |
| req_dspace | input | 1 | Data-side address space |
| req_pid | input | 8 | Current process tag |
| done | output | 1 | Result valid pulse |
| status | output | 2 | 00 ok, 01 miss, 10 data fault, 11 execute fault |
| real_addr | output | 32 | Translated address |
| perm_nib | output | 4 | Rights nibble of the deciding entry |

## Verification
Two functions can meet in one cycle: the write port replacing an entry, and a lookup whose outcome depends on that same entry. The bench drives both in the same cycle. It writes an entry that would turn a miss into a hit while a lookup to that page is pending. The bench expects the miss from the old table contents and expects a hit on the lookup issued in the next cycle. Back-to-back lookups are also run, so a result is presented in the same cycle that the next request is accepted. Each done pulse must still carry the result of its own request.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    typedef enum logic [1:0] {
        XS_OK         = 2'b00,
        XS_MISS       = 2'b01,
        XS_DATA_FAULT = 2'b10,
        XS_EXEC_FAULT = 2'b11
    } xlat_status_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } xlat_state_e;

    // bit positions inside a rights nibble
    localparam int RIGHT_READ  = 0;
    localparam int RIGHT_WRITE = 1;
    localparam int RIGHT_EXEC  = 2;

    // smallest page is 2**MIN_PAGE_W bytes, each size step multiplies by 4
    localparam int MIN_PAGE_W  = 10;
    localparam int SIZE_CODE_W = 4;
    localparam int PERM_W      = 8;

endpackage

// File: rtl/xlat_store.sv
module xlat_store
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int IDX_W   = $clog2(ENTRIES),
    parameter int ADDR_W  = 32,
    parameter int PID_W   = 8
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  wr_en,
    input  logic [IDX_W-1:0]                      wr_idx,
    input  logic                                  wr_valid,
    input  logic [ADDR_W-1:0]                     wr_epn,
    input  logic [SIZE_CODE_W-1:0]                wr_size,
    input  logic [PID_W-1:0]                      wr_pid,
    input  logic                                  wr_space,
    input  logic [ADDR_W-1:0]                     wr_rpn,
    input  logic [PERM_W-1:0]                     wr_perm,
    output logic [ENTRIES-1:0]                    ent_valid,
    output logic [ENTRIES-1:0][ADDR_W-1:0]        ent_epn,
    output logic [ENTRIES-1:0][SIZE_CODE_W-1:0]   ent_size,
    output logic [ENTRIES-1:0][PID_W-1:0]         ent_pid,
    output logic [ENTRIES-1:0]                    ent_space,
    output logic [ENTRIES-1:0][ADDR_W-1:0]        ent_rpn,
    output logic [ENTRIES-1:0][PERM_W-1:0]        ent_perm
);

    // only the valid flags need a reset value
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ent_valid <= '0;
        end else if (wr_en) begin
            ent_valid[wr_idx] <= wr_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            ent_epn[wr_idx]   <= wr_epn;
            ent_size[wr_idx]  <= wr_size;
            ent_pid[wr_idx]   <= wr_pid;
            ent_space[wr_idx] <= wr_space;
            ent_rpn[wr_idx]   <= wr_rpn;
            ent_perm[wr_idx]  <= wr_perm;
        end
    end

    assert_write_lands_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ent_valid[$past(wr_idx)] == $past(wr_valid)));

    assert_no_write_no_change_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ent_valid));

endmodule

// File: rtl/xlat_lane.sv
module xlat_lane
    import xlat_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int PID_W  = 8
) (
    input  logic                    ent_valid,
    input  logic [ADDR_W-1:0]       ent_epn,
    input  logic [SIZE_CODE_W-1:0]  ent_size,
    input  logic [PID_W-1:0]        ent_pid,
    input  logic                    ent_space,
    input  logic [ADDR_W-1:0]       ent_rpn,
    input  logic [PERM_W-1:0]       ent_perm,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic                    req_write,
    input  logic                    req_fetch,
    input  logic                    req_super,
    input  logic                    req_ispace,
    input  logic                    req_dspace,
    input  logic [PID_W-1:0]        req_pid,
    output logic                    eligible,
    output logic                    hit,
    output logic [3:0]              nib,
    output logic [ADDR_W-1:0]       ra
);

    localparam int WIDE_W = 2 * ADDR_W;

    // mask of the address bits at or above the page boundary
    function automatic logic [ADDR_W-1:0] page_mask(input logic [SIZE_CODE_W-1:0] code);
        int          ow;
        logic [WIDE_W-1:0] w;
        ow = MIN_PAGE_W + 2 * int'(code);
        if (ow > ADDR_W) ow = ADDR_W;
        w = {WIDE_W{1'b1}} << ow;
        return w[ADDR_W-1:0];
    endfunction

    logic [ADDR_W-1:0] mask;
    logic              tag_ok;
    logic              pid_ok;
    logic              space_ok;
    logic              right_ok;

    always_comb begin
        mask     = page_mask(ent_size);
        tag_ok   = ((req_addr ^ ent_epn) & mask) == '0;
        pid_ok   = (ent_pid == req_pid) || (ent_pid == '0);
        space_ok = ent_space == (req_fetch ? req_ispace : req_dspace);
        eligible = ent_valid && tag_ok && pid_ok && space_ok;
        nib      = req_super ? ent_perm[7:4] : ent_perm[3:0];
        if (req_fetch)      right_ok = nib[RIGHT_EXEC];
        else if (req_write) right_ok = nib[RIGHT_WRITE];
        else                right_ok = nib[RIGHT_READ];
        hit      = eligible && right_ok;
        ra       = (ent_rpn & mask) | (req_addr & ~mask);
    end

endmodule

// File: rtl/xlat_pick.sv
module xlat_pick #(
    parameter int ENTRIES = 64,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] hit_vec,
    input  logic [ENTRIES-1:0] elig_vec,
    output logic               any_hit,
    output logic [IDX_W-1:0]   hit_idx,
    output logic               any_elig,
    output logic [IDX_W-1:0]   elig_idx
);

    // lowest granting entry, highest eligible entry
    always_comb begin
        any_hit  = |hit_vec;
        any_elig = |elig_vec;
        hit_idx  = '0;
        elig_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) hit_idx = IDX_W'(i);
        end
        for (int i = 0; i < ENTRIES; i++) begin
            if (elig_vec[i]) elig_idx = IDX_W'(i);
        end
    end

    always_comb begin
        if (any_hit) begin
            assert_first_grant_R5: assert (hit_vec[hit_idx] &&
                ((hit_vec & ~({ENTRIES{1'b1}} << hit_idx)) == '0));
        end
        if (any_elig) begin
            assert_last_refuser_R6: assert ((elig_vec >> elig_idx) ==
                {{(ENTRIES-1){1'b0}}, 1'b1});
        end
        assert_grant_needs_space_R7: assert ((hit_vec & ~elig_vec) == '0);
    end

endmodule

// File: rtl/xlat_lookup.sv
module xlat_lookup
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int ADDR_W  = 32,
    parameter int PID_W   = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic                    wr_valid,
    input  logic [ADDR_W-1:0]       wr_epn,
    input  logic [SIZE_CODE_W-1:0]  wr_size,
    input  logic [PID_W-1:0]        wr_pid,
    input  logic                    wr_space,
    input  logic [ADDR_W-1:0]       wr_rpn,
    input  logic [PERM_W-1:0]       wr_perm,
    input  logic                    req,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic                    req_write,
    input  logic                    req_fetch,
    input  logic                    req_super,
    input  logic                    req_ispace,
    input  logic                    req_dspace,
    input  logic [PID_W-1:0]        req_pid,
    output logic                    done,
    output logic [1:0]              status,
    output logic [ADDR_W-1:0]       real_addr,
    output logic [3:0]              perm_nib
);

    logic [ENTRIES-1:0]                  ent_valid;
    logic [ENTRIES-1:0][ADDR_W-1:0]      ent_epn;
    logic [ENTRIES-1:0][SIZE_CODE_W-1:0] ent_size;
    logic [ENTRIES-1:0][PID_W-1:0]       ent_pid;
    logic [ENTRIES-1:0]                  ent_space;
    logic [ENTRIES-1:0][ADDR_W-1:0]      ent_rpn;
    logic [ENTRIES-1:0][PERM_W-1:0]      ent_perm;

    xlat_store #(
        .ENTRIES(ENTRIES), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .PID_W(PID_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid), .wr_epn(wr_epn),
        .wr_size(wr_size), .wr_pid(wr_pid), .wr_space(wr_space),
        .wr_rpn(wr_rpn), .wr_perm(wr_perm),
        .ent_valid(ent_valid), .ent_epn(ent_epn), .ent_size(ent_size),
        .ent_pid(ent_pid), .ent_space(ent_space), .ent_rpn(ent_rpn),
        .ent_perm(ent_perm)
    );

    logic [ENTRIES-1:0]             lane_elig;
    logic [ENTRIES-1:0]             lane_hit;
    logic [ENTRIES-1:0][3:0]        lane_nib;
    logic [ENTRIES-1:0][ADDR_W-1:0] lane_ra;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_lane
        xlat_lane #(.ADDR_W(ADDR_W), .PID_W(PID_W)) u_lane (
            .ent_valid(ent_valid[g]), .ent_epn(ent_epn[g]), .ent_size(ent_size[g]),
            .ent_pid(ent_pid[g]), .ent_space(ent_space[g]), .ent_rpn(ent_rpn[g]),
            .ent_perm(ent_perm[g]),
            .req_addr(req_addr), .req_write(req_write), .req_fetch(req_fetch),
            .req_super(req_super), .req_ispace(req_ispace), .req_dspace(req_dspace),
            .req_pid(req_pid),
            .eligible(lane_elig[g]), .hit(lane_hit[g]), .nib(lane_nib[g]),
            .ra(lane_ra[g])
        );
    end

    logic             any_hit;
    logic             any_elig;
    logic [IDX_W-1:0] hit_idx;
    logic [IDX_W-1:0] elig_idx;

    xlat_pick #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_pick (
        .hit_vec(lane_hit), .elig_vec(lane_elig),
        .any_hit(any_hit), .hit_idx(hit_idx),
        .any_elig(any_elig), .elig_idx(elig_idx)
    );

    // outcome of the scan for the request on the inputs this cycle
    xlat_status_e      st_sel;
    logic [3:0]        nib_sel;
    logic [ADDR_W-1:0] ra_sel;

    always_comb begin
        ra_sel = lane_ra[hit_idx];
        if (any_hit) begin
            st_sel  = XS_OK;
            nib_sel = lane_nib[hit_idx];
        end else if (any_elig) begin
            st_sel  = req_fetch ? XS_EXEC_FAULT : XS_DATA_FAULT;
            nib_sel = lane_nib[elig_idx];
        end else begin
            st_sel  = XS_MISS;
            nib_sel = '0;
        end
    end

    // control state machine
    xlat_state_e state_q;
    xlat_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = req ? ST_REPORT : ST_IDLE;
            ST_REPORT: state_d = req ? ST_REPORT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // result registers
    xlat_status_e      status_q;
    logic [ADDR_W-1:0] ra_q;
    logic [3:0]        nib_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= XS_MISS;
            ra_q     <= '0;
            nib_q    <= '0;
        end else if (req) begin
            status_q <= st_sel;
            nib_q    <= nib_sel;
            if (st_sel == XS_OK) ra_q <= ra_sel;
        end
    end

    assign done      = (state_q == ST_REPORT);
    assign status    = status_q;
    assign real_addr = ra_q;
    assign perm_nib  = nib_q;

    assert_done_has_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(req));

    assert_req_gives_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> done);

    assert_ra_only_on_ok_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(real_addr) |-> (done && status == XS_OK));

    assert_miss_nib_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status == XS_MISS) |-> (perm_nib == '0));

    assert_exec_fault_is_fetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req && st_sel == XS_EXEC_FAULT) |=> (done && status == XS_EXEC_FAULT && $past(req_fetch)));

    assert_data_fault_is_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status == XS_DATA_FAULT) |-> !$past(req_fetch));

endmodule

// File: tb/sim_xlat_lookup.sv
`timescale 1ns/1ps
module sim_xlat_lookup;

    localparam int N = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_idx = '0;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_epn = '0;
    logic [3:0]  wr_size = '0;
    logic [7:0]  wr_pid = '0;
    logic        wr_space = 1'b0;
    logic [31:0] wr_rpn = '0;
    logic [7:0]  wr_perm = '0;
    logic        req = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_fetch = 1'b0;
    logic        req_super = 1'b0;
    logic        req_ispace = 1'b0;
    logic        req_dspace = 1'b0;
    logic [7:0]  req_pid = '0;
    logic        done;
    logic [1:0]  status;
    logic [31:0] real_addr;
    logic [3:0]  perm_nib;

    always #4 clk = ~clk;

    xlat_lookup u0 (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid), .wr_epn(wr_epn),
        .wr_size(wr_size), .wr_pid(wr_pid), .wr_space(wr_space),
        .wr_rpn(wr_rpn), .wr_perm(wr_perm),
        .req(req), .req_addr(req_addr), .req_write(req_write), .req_fetch(req_fetch),
        .req_super(req_super), .req_ispace(req_ispace), .req_dspace(req_dspace),
        .req_pid(req_pid),
        .done(done), .status(status), .real_addr(real_addr), .perm_nib(perm_nib)
    );

    int checks = 0;
    int fails  = 0;
    int reqs   = 0;
    int dones  = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // shadow table built from the requirements
    logic        sh_valid [N];
    logic [31:0] sh_epn   [N];
    logic [3:0]  sh_size  [N];
    logic [7:0]  sh_pid   [N];
    logic        sh_space [N];
    logic [31:0] sh_rpn   [N];
    logic [7:0]  sh_perm  [N];
    logic [31:0] last_ra = '0;

    logic [1:0]  q_st  [$];
    logic [31:0] q_ra  [$];
    logic [3:0]  q_nib [$];
    string       q_tag [$];

    function automatic logic [31:0] mask_of(input logic [3:0] code);
        int ow;
        logic [63:0] w;
        ow = 10 + 2 * int'(code);
        if (ow > 32) ow = 32;
        w = 64'hFFFF_FFFF_FFFF_FFFF << ow;
        return w[31:0];
    endfunction

    task automatic lookup(input string tag, input logic [31:0] a, input logic wr,
                          input logic fe, input logic su, input logic isp,
                          input logic dsp, input logic [7:0] pid);
        logic [1:0]  st;
        logic [31:0] ra;
        logic [3:0]  nb;
        logic        found;
        st = 2'b01; nb = 4'h0; ra = last_ra; found = 1'b0;
        for (int i = 0; i < N; i++) begin
            logic [31:0] m;
            logic [3:0]  n;
            logic        ok;
            m = mask_of(sh_size[i]);
            if (!found && sh_valid[i] && ((a & m) == (sh_epn[i] & m)) &&
                (sh_pid[i] == pid || sh_pid[i] == 8'h00) &&
                (sh_space[i] == (fe ? isp : dsp))) begin
                n  = su ? sh_perm[i][7:4] : sh_perm[i][3:0];
                ok = fe ? n[2] : (wr ? n[1] : n[0]);
                nb = n;
                if (ok) begin
                    st = 2'b00; ra = (sh_rpn[i] & m) | (a & ~m); found = 1'b1;
                end else begin
                    st = fe ? 2'b11 : 2'b10;
                end
            end
        end
        if (st == 2'b00) last_ra = ra;
        q_st.push_back(st); q_ra.push_back(ra); q_nib.push_back(nb); q_tag.push_back(tag);
        req = 1'b1; req_addr = a; req_write = wr; req_fetch = fe; req_super = su;
        req_ispace = isp; req_dspace = dsp; req_pid = pid;
        reqs++;
    endtask

    task automatic put(input int idx, input logic v, input logic [31:0] epn,
                       input logic [3:0] code, input logic [7:0] pid, input logic sp,
                       input logic [31:0] rpn, input logic [7:0] perm);
        wr_en = 1'b1; wr_idx = 6'(idx); wr_valid = v; wr_epn = epn; wr_size = code;
        wr_pid = pid; wr_space = sp; wr_rpn = rpn; wr_perm = perm;
        sh_valid[idx] = v; sh_epn[idx] = epn; sh_size[idx] = code; sh_pid[idx] = pid;
        sh_space[idx] = sp; sh_rpn[idx] = rpn; sh_perm[idx] = perm;
    endtask

    task automatic step();
        @(negedge clk);
        wr_en = 1'b0;
        req   = 1'b0;
    endtask

    // monitor: pops one expected item per done pulse
    always @(negedge clk) begin
        if (rst_n && done) begin
            dones++;
            if (q_st.size() == 0) begin
                check("R2 done without pending request", 32'd1, 32'd0);
            end else begin
                string t;
                t = q_tag.pop_front();
                check({t, " status"}, 32'(status), 32'(q_st.pop_front()));
                check({t, " real_addr"}, real_addr, q_ra.pop_front());
                check({t, " perm_nib"}, 32'(perm_nib), 32'(q_nib.pop_front()));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            sh_valid[i] = 1'b0; sh_epn[i] = '0; sh_size[i] = '0; sh_pid[i] = '0;
            sh_space[i] = 1'b0; sh_rpn[i] = '0; sh_perm[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 done after reset", 32'(done), 32'd0);
        check("R1 status after reset", 32'(status), 32'd1);
        check("R1 real_addr after reset", real_addr, 32'd0);
        check("R1 perm_nib after reset", 32'(perm_nib), 32'd0);
        lookup("R1 empty table misses", 32'h0001_0123, 0, 0, 0, 0, 0, 8'd5); step();
        step();
        check("R2 done low when idle", 32'(done), 32'd0);

        // e0: 4 KiB, tag 5, space 0, super RW, user R
        put(0, 1, 32'h0001_0000, 4'd1, 8'd5, 0, 32'h8000_0000, 8'h31); step();
        lookup("R3 R4 user read hit", 32'h0001_0123, 0, 0, 0, 0, 0, 8'd5); step();
        lookup("R9 user write refused", 32'h0001_0123, 1, 0, 0, 0, 0, 8'd5); step();
        lookup("R6 supervisor write granted", 32'h0001_0ABC, 1, 0, 1, 0, 0, 8'd5); step();
        lookup("R8 fetch refused", 32'h0001_0010, 0, 1, 1, 0, 0, 8'd5); step();
        lookup("R3 other tag misses", 32'h0001_0010, 0, 0, 1, 0, 0, 8'd6); step();
        lookup("R3 page above boundary misses", 32'h0001_1010, 0, 0, 1, 0, 0, 8'd5); step();

        // e5: global, space 0, all rights
        put(5, 1, 32'h0001_0000, 4'd1, 8'd0, 0, 32'h9000_0000, 8'h77); step();
        lookup("R8 fetch falls through to later entry", 32'h0001_0123, 0, 1, 1, 0, 0, 8'd5); step();
        lookup("R9 write falls through", 32'h0001_0123, 1, 0, 0, 0, 0, 8'd5); step();
        lookup("R3 global tag matches", 32'h0001_0456, 0, 0, 0, 0, 0, 8'd7); step();

        // e2: tag 5, space 1
        put(2, 1, 32'h0001_0000, 4'd1, 8'd5, 1, 32'hA000_0000, 8'h77); step();
        lookup("R7 data space 1 skips space 0", 32'h0001_0044, 0, 0, 0, 0, 1, 8'd5); step();
        lookup("R7 fetch uses instr space", 32'h0001_0044, 0, 1, 0, 1, 0, 8'd5); step();
        lookup("R7 fetch space 0 ignores data bit", 32'h0001_0044, 0, 1, 1, 0, 1, 8'd5); step();

        // e3 duplicates e0 tag with all rights: e0 still wins
        put(3, 1, 32'h0001_0000, 4'd1, 8'd5, 0, 32'hB000_0000, 8'h77); step();
        lookup("R5 lowest granting index wins", 32'h0001_0200, 0, 0, 0, 0, 0, 8'd5); step();

        // e10: size code 4, offset 18 bits, epn low bits ignored
        put(10, 1, 32'h0040_1234, 4'd4, 8'd0, 0, 32'hC000_0000, 8'h11); step();
        lookup("R4 large page offset", 32'h0043_ABCD, 0, 0, 0, 0, 0, 8'd3); step();
        lookup("R10 miss holds real_addr", 32'h0044_0000, 0, 0, 0, 0, 0, 8'd3); step();

        // e20/e21: both refuse a user write, highest refuser reported
        put(20, 1, 32'h0100_0000, 4'd1, 8'd0, 0, 32'hD000_0000, 8'h01); step();
        put(21, 1, 32'h0100_0000, 4'd1, 8'd0, 0, 32'hE000_0000, 8'h04); step();
        lookup("R6 fault reports last refuser", 32'h0100_0008, 1, 0, 0, 0, 0, 8'd1); step();
        put(21, 0, 32'h0100_0000, 4'd1, 8'd0, 0, 32'hE000_0000, 8'h04); step();
        lookup("R3 invalid entry ignored", 32'h0100_0008, 1, 0, 0, 0, 0, 8'd1); step();
        lookup("R10 wrong space only gives miss", 32'h0100_0008, 0, 0, 0, 0, 1, 8'd1); step();

        // R11 same-cycle write and lookup
        lookup("R11 lookup sees old contents", 32'h0200_0010, 0, 0, 0, 0, 0, 8'd1);
        put(30, 1, 32'h0200_0000, 4'd1, 8'd0, 0, 32'hF000_0000, 8'h01); step();
        lookup("R11 next lookup sees new entry", 32'h0200_0010, 0, 0, 0, 0, 0, 8'd1); step();

        // size code capped at address width: whole space maps
        put(40, 1, 32'h0000_0000, 4'd15, 8'd9, 0, 32'h5555_5555, 8'h10); step();
        lookup("R3 capped size maps all addresses", 32'h1234_5678, 0, 0, 1, 0, 0, 8'd9); step();

        // R2 back-to-back requests
        lookup("R2 back-to-back first", 32'h0001_0001, 0, 0, 0, 0, 0, 8'd5); step();
        lookup("R2 back-to-back second", 32'h0043_0002, 0, 0, 0, 0, 0, 8'd5); step();
        lookup("R2 back-to-back third", 32'h0300_0000, 0, 0, 0, 0, 0, 8'd5); step();
        step();
        step();
        check("R2 done count matches requests", 32'(dones), 32'(reqs));
        check("R2 no expected result left over", 32'(q_st.size()), 32'd0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule